// File: doc/BRIEF.md
# Dual-Channel ADC Serial Capture Controller

This block runs the host side of the serial link to a simultaneous-sampling converter that delivers two 12-bit results per conversion. It drives the conversion strobe and the serial clock and collects the returned bits. Both results are then presented together, with a one-cycle valid pulse. The serial clock runs at a programmable fraction of the system clock.

Two wiring modes are supported. In the two-line mode each channel has its own data line and a frame is 16 serial clocks. In the one-line mode both results share line A and a frame is 28 serial clocks. A start command opens a frame and the strobe is raised a fixed number of system clocks before the first serial clock rise.

The strobe falls after the first serial clock. Mid-frame it either returns high, which keeps the converter awake and allows back-to-back frames, or stays low through the end of the frame, which asks the converter to power down. In continuous operation frames follow one another with no setup gap until the continuous request is withdrawn. The parameter LEAD_BITS must not exceed 4.

Top module: `dadc_capture_ctrl`

## Requirements
- R1: After reset, cnvst_o and sclk_o are low, valid_o is low and both results read zero.
- R2: A start command raises cnvst_o with sclk_o low, and the first sclk_o rise follows exactly SETUP_CLKS system clocks later, with cnvst_o still high.
- R3: Within a burst every sclk_o high and low phase lasts max(half_per_i, 1) system clocks, including the low phase that joins two continuous frames.
- R4: A frame has exactly 16 sclk_o rises in two-line mode (single_i = 0) and 28 in one-line mode (single_i = 1). After a frame that is not continued, sclk_o stays low.
- R5: cnvst_o falls on the 1st falling sclk_o edge of a frame. It rises again on the 14th falling edge unless pdn_req_i is high at that edge.
- R6: In two-line mode, bits are taken on falling sclk_o edges LEAD_BITS+1 through LEAD_BITS+12, most significant bit first. ch1_o is built from dout_a_i and ch2_o from dout_b_i.
- R7: In one-line mode, falling edges LEAD_BITS+1..LEAD_BITS+12 of dout_a_i form ch1_o and edges LEAD_BITS+13..LEAD_BITS+24 form ch2_o, MSB first. dout_b_i has no effect.
- R8: valid_o is high for exactly one cycle per frame, in the cycle after the last data bit is taken. ch1_o and ch2_o change only in that cycle.
- R9: With cont_i high at the end of a frame, the next frame starts without a setup phase. The stream stops after the first frame that ends with cont_i low.
- R10: If cnvst_o is low at the last falling edge of a frame, the block stays with cnvst_o and sclk_o low until the next start command.
- R11: The mode is taken from single_i when a frame sequence starts. start_i and single_i changes during a running sequence have no effect, and a one-shot frame without power-down ends with cnvst_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a frame sequence (taken only when idle or powered down) |
| cont_i | input | 1 | Continue with another frame at end of frame |
| pdn_req_i | input | 1 | Request power-down, sampled on the 14th falling edge |
| single_i | input | 1 | 1 = one-line 28-clock mode, 0 = two-line 16-clock mode |
| half_per_i | input | HALF_W | Serial clock half period in system clocks (0 acts as 1) |
| dout_a_i | input | 1 | Converter data line A |
| dout_b_i | input | 1 | Converter data line B |
| cnvst_o | output | 1 | Conversion strobe |
| sclk_o | output | 1 | Serial clock |
| ch1_o | output | 12 | Channel 1 result |
| ch2_o | output | 12 | Channel 2 result |
| valid_o | output | 1 | One-cycle pulse: results updated |

## Verification
A wrong falling-edge count shows within one frame. Either the strobe edges land on the wrong serial clock edge, or the number of rises per frame is off, or a result comes back bit-shifted against the data the converter model sent. A wrong state at end of frame shows in the idle cycles right after it: the serial clock keeps toggling, stays idle when it should continue, or the strobe rests at the wrong level. A stuck capture register shows at the next valid pulse as a result that differs from the random sample pushed for that frame.

// File: rtl/dadc_pkg.sv
package dadc_pkg;
    localparam int unsigned SAMPLE_W     = 12;
    localparam int unsigned DUAL_FRAME   = 16;
    localparam int unsigned SINGLE_FRAME = 28;
    localparam int unsigned REARM_EDGE   = 14;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2,
        ST_PDN   = 2'd3
    } st_e;
endpackage

// File: rtl/dadc_sclk_gen.sv
module dadc_sclk_gen #(
    parameter int unsigned HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              launch_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              sclk_o,
    output logic              fall_o
);
    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

    typedef struct packed {
        logic              sclk;
        logic [HALF_W-1:0] hc;
    } gen_t;

    gen_t q, d;
    logic [HALF_W-1:0] eff;
    logic              tick;

    always_comb begin
        eff    = (half_i == '0) ? ONE : half_i;
        tick   = run_i && (q.hc == eff - ONE);
        fall_o = tick && q.sclk;
        d      = q;
        if (launch_i) begin
            d.sclk = 1'b1;
            d.hc   = '0;
        end else if (run_i) begin
            if (tick) begin
                d.sclk = ~q.sclk;
                d.hc   = '0;
            end else begin
                d.hc = q.hc + ONE;
            end
        end else begin
            d.sclk = 1'b0;
            d.hc   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_o = q.sclk;
endmodule

// File: rtl/dadc_shift_capture.sv
module dadc_shift_capture #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         single_i,
    input  logic         commit_i,
    input  logic         bit_a_i,
    input  logic         bit_b_i,
    output logic [W-1:0] res1_o,
    output logic [W-1:0] res2_o,
    output logic         valid_o
);
    typedef struct packed {
        logic [W-1:0] sr1;
        logic [W-1:0] sr2;
        logic [W-1:0] r1;
        logic [W-1:0] r2;
        logic         vld;
    } cap_t;

    cap_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (shift_i) begin
            if (single_i) begin
                // one 2W-bit chain: line A enters sr2, sr2 MSB feeds sr1
                d.sr2 = {q.sr2[W-2:0], bit_a_i};
                d.sr1 = {q.sr1[W-2:0], q.sr2[W-1]};
            end else begin
                d.sr1 = {q.sr1[W-2:0], bit_a_i};
                d.sr2 = {q.sr2[W-2:0], bit_b_i};
            end
        end
        if (commit_i) begin
            d.r1  = d.sr1;
            d.r2  = d.sr2;
            d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res1_o  = q.r1;
    assign res2_o  = q.r2;
    assign valid_o = q.vld;
endmodule

// File: rtl/dadc_capture_ctrl.sv
module dadc_capture_ctrl
    import dadc_pkg::*;
#(
    parameter int unsigned HALF_W     = 8,
    parameter int unsigned SETUP_CLKS = 3,
    parameter int unsigned LEAD_BITS  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cont_i,
    input  logic                pdn_req_i,
    input  logic                single_i,
    input  logic [HALF_W-1:0]   half_per_i,
    input  logic                dout_a_i,
    input  logic                dout_b_i,
    output logic                cnvst_o,
    output logic                sclk_o,
    output logic [SAMPLE_W-1:0] ch1_o,
    output logic [SAMPLE_W-1:0] ch2_o,
    output logic                valid_o
);
    localparam int unsigned EC_W = $clog2(SINGLE_FRAME + 1);
    localparam int unsigned SC_W = (SETUP_CLKS > 1) ? $clog2(SETUP_CLKS) : 1;
    localparam logic [EC_W-1:0] E_ONE   = EC_W'(1);
    localparam logic [EC_W-1:0] E_REARM = EC_W'(REARM_EDGE);
    localparam logic [EC_W-1:0] E_LEAD  = EC_W'(LEAD_BITS);
    localparam logic [EC_W-1:0] LEN_D   = EC_W'(DUAL_FRAME);
    localparam logic [EC_W-1:0] LEN_S   = EC_W'(SINGLE_FRAME);
    localparam logic [EC_W-1:0] LAST_D  = EC_W'(LEAD_BITS + SAMPLE_W);
    localparam logic [EC_W-1:0] LAST_S  = EC_W'(LEAD_BITS + 2 * SAMPLE_W);
    localparam logic [SC_W-1:0] SC_END  = SC_W'(SETUP_CLKS - 1);

    typedef struct packed {
        st_e             st;
        logic [SC_W-1:0] scnt;
        logic [EC_W-1:0] ec;
        logic            cnvst;
        logic            single;
    } ctl_t;

    ctl_t q, d;
    logic            run, launch, fall, shift, commit;
    logic [EC_W-1:0] fidx, flen, flast;

    dadc_sclk_gen #(.HALF_W(HALF_W)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .launch_i (launch),
        .half_i   (half_per_i),
        .sclk_o   (sclk_o),
        .fall_o   (fall)
    );

    dadc_shift_capture #(.W(SAMPLE_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (shift),
        .single_i (q.single),
        .commit_i (commit),
        .bit_a_i  (dout_a_i),
        .bit_b_i  (dout_b_i),
        .res1_o   (ch1_o),
        .res2_o   (ch2_o),
        .valid_o  (valid_o)
    );

    always_comb begin
        d      = q;
        run    = (q.st == ST_RUN);
        launch = 1'b0;
        shift  = 1'b0;
        commit = 1'b0;
        flen   = q.single ? LEN_S  : LEN_D;
        flast  = q.single ? LAST_S : LAST_D;
        fidx   = q.ec + E_ONE;
        unique case (q.st)
            ST_IDLE, ST_PDN: begin
                if (start_i) begin
                    d.st     = ST_SETUP;
                    d.scnt   = '0;
                    d.ec     = '0;
                    d.cnvst  = 1'b1;
                    d.single = single_i;
                end
            end
            ST_SETUP: begin
                if (q.scnt == SC_END) begin
                    launch = 1'b1;
                    d.st   = ST_RUN;
                end else begin
                    d.scnt = q.scnt + SC_W'(1);
                end
            end
            ST_RUN: begin
                if (fall) begin
                    d.ec = fidx;
                    if (fidx == E_ONE)                  d.cnvst = 1'b0;
                    if (fidx == E_REARM && !pdn_req_i)  d.cnvst = 1'b1;
                    if (fidx > E_LEAD && fidx <= flast) shift = 1'b1;
                    if (fidx == flast)                  commit = 1'b1;
                    if (fidx == flen) begin
                        d.ec = '0;
                        if (!q.cnvst)     d.st = ST_PDN;
                        else if (!cont_i) d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign cnvst_o = q.cnvst;
endmodule

// File: rtl/dadc_capture_ctrl_chk.sv
module dadc_capture_ctrl_chk
    import dadc_pkg::*;
#(
    parameter int unsigned EC_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cnvst,
    input logic                sclk,
    input logic                valid,
    input logic [SAMPLE_W-1:0] ch1,
    input logic [SAMPLE_W-1:0] ch2,
    input logic [EC_W-1:0]     ec,
    input logic                single,
    input st_e                 state
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(ch1) && $stable(ch2))); // R8
    AST_VALID_AT_SCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $fell(sclk)); // R6
    AST_STROBE_FALL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnvst) |-> $fell(sclk)); // R5
    AST_STROBE_RISE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnvst) |-> !sclk); // R2
    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ec <= (single ? EC_W'(SINGLE_FRAME) : EC_W'(DUAL_FRAME))); // R4
    AST_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDN) |-> (!cnvst && !sclk)); // R10
endmodule

bind dadc_capture_ctrl dadc_capture_ctrl_chk #(.EC_W(EC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnvst  (cnvst_o),
    .sclk   (sclk_o),
    .valid  (valid_o),
    .ch1    (ch1_o),
    .ch2    (ch2_o),
    .ec     (q.ec),
    .single (q.single),
    .state  (q.st)
);

// File: tb/test_dadc_capture_ctrl.sv
`timescale 1ns/1ps
module test_dadc_capture_ctrl;
    localparam int SETUP = 3;
    localparam int LEAD  = 4;
    localparam int TCLK  = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, cont_i = 0, pdn_req_i = 0, single_i = 0;
    logic [7:0] half_per_i = 8'd1;
    logic dout_a_i = 0, dout_b_i = 0;
    logic cnvst_o, sclk_o, valid_o;
    logic [11:0] ch1_o, ch2_o;

    always #(TCLK/2) clk = ~clk;

    dadc_capture_ctrl #(.HALF_W(8), .SETUP_CLKS(SETUP), .LEAD_BITS(LEAD)) i_dadc_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .pdn_req_i(pdn_req_i), .single_i(single_i), .half_per_i(half_per_i),
        .dout_a_i(dout_a_i), .dout_b_i(dout_b_i), .cnvst_o(cnvst_o),
        .sclk_o(sclk_o), .ch1_o(ch1_o), .ch2_o(ch2_o), .valid_o(valid_o)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // bench-side settings of the running sequence
    bit  m_single = 0;
    int  m_len = 16, m_half = 1;
    int  fr_model = 0, fr_mon = 0;
    time t_start = 0, last_t = 0;
    logic [11:0] m_a, m_b;
    logic [11:0] exp_a[$], exp_b[$];
    int rises = 0, bad_setup = 0, bad_half = 0, bad_strobe = 0, bad_valid = 0;

    // converter model: new bit after each sclk rise, taken at the next fall
    initial forever begin
        @(posedge sclk_o);
        fr_model = (fr_model >= m_len) ? 1 : fr_model + 1;
        if (fr_model == 1) begin
            m_a = 12'($urandom);
            m_b = 12'($urandom);
            exp_a.push_back(m_a);
            exp_b.push_back(m_b);
        end
        dout_a_i = 1'($urandom);
        dout_b_i = 1'($urandom);
        if (fr_model > LEAD && fr_model <= LEAD + 12) begin
            dout_a_i = m_a[11 - (fr_model - LEAD - 1)];
            if (!m_single) dout_b_i = m_b[11 - (fr_model - LEAD - 1)];
        end
        if (m_single && fr_model > LEAD + 12 && fr_model <= LEAD + 24)
            dout_a_i = m_b[11 - (fr_model - LEAD - 13)];
    end

    // port monitor, sampling away from the active edge
    logic ps = 0, pc = 0, pv = 0;
    logic [11:0] p1 = 0, p2 = 0;
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (cnvst_o && !pc) begin
                if (!sclk_o && ps) begin
                    if (fr_mon != 14) bad_strobe++;          // R5 rise at 14th fall
                end else if (sclk_o || fr_mon != 0) bad_strobe++; // R2
            end
            if (!cnvst_o && pc && !(ps && !sclk_o && fr_mon == 1)) bad_strobe++; // R5
            if (sclk_o && !ps) begin
                rises++;
                if (fr_mon == 0) begin
                    if ($time - t_start != (SETUP + 1) * TCLK || !cnvst_o) bad_setup++; // R2
                end else if ($time - last_t != m_half * TCLK) bad_half++; // R3
                fr_mon = (fr_mon >= m_len) ? 1 : fr_mon + 1;
                last_t = $time;
            end
            if (!sclk_o && ps) begin
                if ($time - last_t != m_half * TCLK) bad_half++;  // R3
                last_t = $time;
            end
            if (valid_o) begin
                if (pv) bad_valid++;                         // R8
                if (exp_a.size() == 0) chk(0, "R8", "valid without frame", 1, 0);
                else begin
                    logic [11:0] ea, eb;
                    ea = exp_a.pop_front();
                    eb = exp_b.pop_front();
                    chk(ch1_o == ea, m_single ? "R7" : "R6", "ch1 sample", ch1_o, ea);
                    chk(ch2_o == eb, m_single ? "R7" : "R6", "ch2 sample", ch2_o, eb);
                end
            end else if (ch1_o != p1 || ch2_o != p2) bad_valid++; // R8
        end
        ps = sclk_o; pc = cnvst_o; pv = valid_o; p1 = ch1_o; p2 = ch2_o;
    end

    task automatic run(input bit single, input int half, input int nf,
                       input bit pdn, input bit disturb);
        int r0, bs0, bh0, bst0, bv0;
        @(negedge clk);
        exp_a.delete(); exp_b.delete();
        m_single = single; m_len = single ? 28 : 16;
        m_half = (half == 0) ? 1 : half;
        fr_model = 0; fr_mon = 0;
        r0 = rises; bs0 = bad_setup; bh0 = bad_half; bst0 = bad_strobe; bv0 = bad_valid;
        single_i = single; half_per_i = 8'(half);
        cont_i = (nf > 1); pdn_req_i = pdn && (nf == 1);
        start_i = 1; t_start = $time;
        @(negedge clk);
        start_i = 0;
        if (disturb) begin
            repeat (10) @(negedge clk);
            start_i = 1; single_i = ~single;                 // R11 ignored mid-run
            @(negedge clk);
            start_i = 0;
        end
        for (int k = 1; k <= nf; k++) begin
            do @(negedge clk); while (!valid_o);
            if (k == nf - 1) begin
                cont_i = 0;
                pdn_req_i = pdn;
            end
        end
        repeat (6 * m_half + 12) @(negedge clk);
        chk(sclk_o == 0, "R4", "sclk idle after last frame", sclk_o, 0);
        chk(rises - r0 == nf * m_len, nf > 1 ? "R9" : (disturb ? "R11" : "R4"),
            "sclk rises in sequence", rises - r0, nf * m_len);
        chk(cnvst_o == !pdn, pdn ? "R10" : "R11", "strobe level at rest", cnvst_o, !pdn);
        chk(bad_setup == bs0, "R2", "setup lead errors", bad_setup - bs0, 0);
        chk(bad_half == bh0, "R3", "half period errors", bad_half - bh0, 0);
        chk(bad_strobe == bst0, "R5", "strobe edge errors", bad_strobe - bst0, 0);
        chk(bad_valid == bv0, "R8", "valid/result hold errors", bad_valid - bv0, 0);
        chk(exp_a.size() == 0, "R8", "frames without valid", exp_a.size(), 0);
        if (pdn) begin
            repeat (40) @(negedge clk);
            chk(!cnvst_o && !sclk_o, "R10", "power-down stays quiet",
                {cnvst_o, sclk_o}, 0);
        end
        cont_i = 0; pdn_req_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (4) @(negedge clk);
        chk(!cnvst_o && !sclk_o && !valid_o, "R1", "outputs in reset",
            {cnvst_o, sclk_o, valid_o}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(ch1_o == 0 && ch2_o == 0 && !cnvst_o && !sclk_o, "R1", "state after reset",
            {ch1_o, ch2_o}, 0);
        run(0, 2, 1, 0, 0);   // two-line one-shot
        run(1, 1, 1, 0, 0);   // one-line one-shot, line B junk
        run(0, 0, 3, 0, 0);   // half period 0 acts as 1, continuous
        run(1, 3, 2, 1, 0);   // one-line continuous ending in power-down
        run(0, 1, 1, 1, 0);   // two-line power-down
        run(1, 2, 1, 0, 1);   // mid-run start and mode change
        run(0, 2, 2, 0, 1);
        for (int i = 0; i < 10; i++)
            run(1'($urandom), int'($urandom % 5), 1 + int'($urandom % 3),
                1'($urandom), 1'($urandom));
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule